// File: doc/BRIEF.md
# Match-Reload Timer Channel with Captured Count Readout

This block is one 32-bit up-counting timer channel on a small word-addressed register bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. Once it is enabled, the counter advances by one every clock. Three match comparators watch the count. A reload-select register chooses which of them, if any, reloads the counter from a preload register when the count reaches it. Every comparator sets a sticky status bit when its value is reached. A status bit whose interrupt-enable bit is also set drives the interrupt output.

Software never reads the running count directly. It writes 1 to a capture register. After a fixed two-cycle busy window the block copies the count into a holding register, and software then reads that holding register. If match 0 is all ones, the preload is 0 and match 0 is selected for reload, the channel runs as a free-running 32-bit counter.

Top module: `tmr_channel`

## Requirements
- R1: After reset: counter 0, enable 0, all match registers all ones, preload 0, reload select 0, status 0, interrupt enables 0, captured value 0, `irq` low.
- R2: Bit 0 of the control register (word 0x0) enables counting. While it is 1 the count rises by one per clock. While it is 0 the count holds.
- R3: Writing the count register (word 0xA) loads the counter with the write data. Reading word 0xA returns 0.
- R4: Reload select (word 0x5, bits [1:0]) uses these codes: 0 means no reload, 1 picks match 0, 2 picks match 1, 3 picks match 2. While enabled, a count equal to the selected match makes the next count equal the preload value. A count equal to a match that is not selected keeps counting up.
- R5: A count of all ones wraps to 0 on the next enabled clock.
- R6: Writing the preload register (word 0x4) leaves the count unchanged.
- R7: While enabled, a count equal to match i (words 0x1+i) sets status bit i (word 0x6, bits [2:0]). The bit stays set until it is cleared.
- R8: `irq` is high exactly when some status bit and its enable bit (word 0x7, bits [2:0]) are both 1.
- R9: Writing 1 in bit i of the clear register (word 0x8) clears status bit i. A new match in the same cycle wins over the clear.
- R10: A write with bit 0 set to the capture register (word 0x9) starts a capture. Two clock edges after the write edge, the holding register takes the count. A write with bit 0 clear has no effect.
- R11: A read of word 0x9 returns the holding register. During the busy window it returns the previous captured value.
- R12: Read data appears the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt output |

## Verification
Counting is run in several configurations, each read back through a capture. A plain run with no reload in range checks the step size. A run through the selected match 0 checks the reload to the preload value. Selecting match 1 shows that the select code picks the right comparator. With select 0 the same match value gives no reload. A start just below all ones checks the wrap. Captures are taken with the counter stopped, so that each expected value is exact. One read falls inside the busy window and must return the older value. One capture write with bit 0 clear must leave the holding register alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int N_CMP = 3;
    localparam int SEL_W = 2;

    typedef enum logic [3:0] {
        A_CTRL    = 4'h0,
        A_MATCH0  = 4'h1,
        A_MATCH1  = 4'h2,
        A_MATCH2  = 4'h3,
        A_PRELOAD = 4'h4,
        A_RLDSEL  = 4'h5,
        A_STATUS  = 4'h6,
        A_IRQEN   = 4'h7,
        A_IRQCLR  = 4'h8,
        A_CAPTURE = 4'h9,
        A_COUNT   = 4'hA
    } tmr_addr_e;
endpackage

// File: rtl/tmr_match_bank.sv
module tmr_match_bank #(
    parameter int W = 32,
    parameter int N = 3,
    parameter int SW = 2
) (
    input  logic [W-1:0]        count,
    input  logic [N-1:0][W-1:0] match,
    input  logic [SW-1:0]       sel,
    output logic [N-1:0]        hit,
    output logic                reload_hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = (count == match[i]);
    end

    always_comb begin
        reload_hit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sel == SW'(i + 1)) reload_hit = hit[i];
        end
    end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int W = 32,
    parameter int BUSY_CYC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [W-1:0] count,
    output logic [W-1:0] held,
    output logic         busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  held;
    } cap_t;

    cap_t d, q;

    always_comb begin
        d = q;
        if (req) begin
            d.cnt = CW'(BUSY_CYC);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) d.held = count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign held = q.held;
    assign busy = (q.cnt != '0);

    assert_busy_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == CW'(BUSY_CYC) && !req) |=> (q.cnt == CW'(BUSY_CYC - 1)));
    assert_held_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != CW'(1)) |=> $stable(q.held));
    assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> busy);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int W = 32,
    parameter int BUSY_CYC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic         bus_wr,
    input  logic         bus_rd,
    output logic [W-1:0] bus_rdata,
    output logic         irq
);
    import tmr_pkg::*;

    typedef struct packed {
        logic                    en;
        logic [N_CMP-1:0][W-1:0] match;
        logic [W-1:0]            preload;
        logic [SEL_W-1:0]        sel;
        logic [N_CMP-1:0]        status;
        logic [N_CMP-1:0]        irqen;
        logic [W-1:0]            count;
        logic [W-1:0]            rdata;
    } regs_t;

    regs_t d, q;

    logic [N_CMP-1:0] hit, evt, clr_mask;
    logic             reload_hit, load, cap_req, cap_busy;
    logic [W-1:0]     cap_val;

    tmr_match_bank #(.W(W), .N(N_CMP), .SW(SEL_W)) u_bank (
        .count(q.count), .match(q.match), .sel(q.sel),
        .hit(hit), .reload_hit(reload_hit)
    );

    tmr_capture #(.W(W), .BUSY_CYC(BUSY_CYC)) u_cap (
        .clk(clk), .rst_n(rst_n), .req(cap_req), .count(q.count),
        .held(cap_val), .busy(cap_busy)
    );

    assign load     = bus_wr && (bus_addr == A_COUNT);
    assign cap_req  = bus_wr && (bus_addr == A_CAPTURE) && bus_wdata[0];
    assign evt      = hit & {N_CMP{q.en}};
    assign clr_mask = (bus_wr && bus_addr == A_IRQCLR) ? bus_wdata[N_CMP-1:0] : '0;

    always_comb begin
        d = q;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL:    d.en = bus_wdata[0];
                A_PRELOAD: d.preload = bus_wdata;
                A_RLDSEL:  d.sel = bus_wdata[SEL_W-1:0];
                A_IRQEN:   d.irqen = bus_wdata[N_CMP-1:0];
                default: begin
                    for (int i = 0; i < N_CMP; i++)
                        if (bus_addr == 4'(A_MATCH0 + i)) d.match[i] = bus_wdata;
                end
            endcase
        end
        if (load)         d.count = bus_wdata;
        else if (q.en)    d.count = reload_hit ? q.preload : q.count + 1'b1;
        d.status = (q.status & ~clr_mask) | evt;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:    d.rdata = W'(q.en);
                A_PRELOAD: d.rdata = q.preload;
                A_RLDSEL:  d.rdata = W'(q.sel);
                A_STATUS:  d.rdata = W'(q.status);
                A_IRQEN:   d.rdata = W'(q.irqen);
                A_CAPTURE: d.rdata = cap_val;
                default: begin
                    d.rdata = '0;
                    for (int i = 0; i < N_CMP; i++)
                        if (bus_addr == 4'(A_MATCH0 + i)) d.rdata = q.match[i];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.match <= '1;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata = q.rdata;
    assign irq       = |(q.status & q.irqen);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en && !load) |=> $stable(q.count));
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.en && !load && !reload_hit) |=> (q.count == $past(q.count) + 1'b1));
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.en && reload_hit && !load) |=> (q.count == $past(q.preload)));
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.en && q.count == '1 && !reload_hit && !load) |=> (q.count == '0));
    assert_status_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((q.status & $past(evt)) == $past(evt)));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|clr_mask) && !(|evt)) |=> ((q.status & $past(clr_mask)) == '0));
    assert_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    assert_busy_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_busy && bus_rd && bus_addr == A_CAPTURE && !$past(cap_busy))
        |=> (bus_rdata == $past(cap_val)));
endmodule

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        pend = 1'b0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    tmr_channel u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: compares read data one cycle after the read strobe
    always @(posedge clk) pend <= bus_rd;
    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, bus_rdata, e);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [3:0] a, input logic [31:0] v, input string tag);
        @(negedge clk);
        exp_q.push_back(v); tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic capture_exp(input logic [31:0] v, input string tag);
        wr(4'h9, 32'h1);
        idle(2);
        rd_exp(4'h9, v, tag);
    endtask

    // enable, k idle cycles, disable: k+2 increments
    task automatic run(input int k);
        wr(4'h0, 32'h1);
        idle(k);
        wr(4'h0, 32'h0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd_exp(4'h0, 32'h0, "R1 ctrl");
        rd_exp(4'h1, 32'hFFFF_FFFF, "R1 match0");
        rd_exp(4'h6, 32'h0, "R1 status");
        rd_exp(4'h9, 32'h0, "R1 capture");
        capture_exp(32'h0, "R1 count");
        // R3 load and count readback
        wr(4'hA, 32'h1234);
        rd_exp(4'hA, 32'h0, "R3 count read zero");
        capture_exp(32'h1234, "R3/R10 loaded count captured");
        // R6 preload write leaves count
        wr(4'h4, 32'hABCD);
        capture_exp(32'h1234, "R6 preload no effect");
        // R11 read in busy window returns previous
        wr(4'hA, 32'h55);
        wr(4'h9, 32'h1);
        rd_exp(4'h9, 32'h1234, "R11 busy read old");
        idle(2);
        rd_exp(4'h9, 32'h55, "R11 after busy new");
        // R10 bit0 clear ignored
        wr(4'hA, 32'h77);
        wr(4'h9, 32'h2);
        idle(3);
        rd_exp(4'h9, 32'h55, "R10 bit0 clear ignored");
        // R12 rdata holds without read strobe
        wr(4'h4, 32'h0);
        idle(1);
        check("R12 rdata hold", bus_rdata, 32'h55);
        // R2 counting and hold
        wr(4'hA, 32'd100);
        run(3);
        capture_exp(32'd105, "R2 count step");
        idle(5);
        capture_exp(32'd105, "R2 hold when disabled");
        // R4 reload via match0
        wr(4'h8, 32'h7);
        wr(4'h1, 32'd10);
        wr(4'h4, 32'd3);
        wr(4'h5, 32'd1);
        wr(4'hA, 32'd8);
        run(3);
        capture_exp(32'd5, "R4 reload match0");
        rd_exp(4'h6, 32'h1, "R7 status bit0");
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(4'h7, 32'h1);
        check("R8 irq enabled", {31'b0, irq}, 32'h1);
        wr(4'h8, 32'h1);
        rd_exp(4'h6, 32'h0, "R9 status cleared");
        check("R9 irq cleared", {31'b0, irq}, 32'h0);
        // R4 select code 2 picks match1
        wr(4'h2, 32'd5);
        wr(4'h4, 32'd100);
        wr(4'h5, 32'd2);
        wr(4'hA, 32'd4);
        run(1);
        capture_exp(32'd101, "R4 reload match1");
        rd_exp(4'h6, 32'h2, "R7 status bit1");
        // R4 select 0: no reload
        wr(4'h8, 32'h7);
        wr(4'h5, 32'd0);
        wr(4'hA, 32'd8);
        run(3);
        capture_exp(32'd13, "R4 no reload sel0");
        rd_exp(4'h6, 32'h1, "R7 status sticky without reload");
        // R5 free-running wrap
        wr(4'h1, 32'hFFFF_FFFF);
        wr(4'h4, 32'h0);
        wr(4'h5, 32'd1);
        wr(4'hA, 32'hFFFF_FFFD);
        run(2);
        capture_exp(32'h1, "R5 wrap");
        idle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule